// File: doc/BRIEF.md
# Parallel Ferroelectric Memory Bus Controller

This block sits between a synchronous host and a byte-wide parallel ferroelectric memory. It turns one-word read and write requests into the strobe sequences the memory needs. The host offers a request with a valid/ready handshake, carrying a 15-bit word address, a write flag and a data byte. A read returns its byte with a one-clock valid pulse.

On the memory side the controller drives three active-low strobes: chip select, output gate and write strobe. It also drives the address bus and the data byte, with a separate drive-enable, and it reads the returned byte on a separate input. The memory takes the address on the falling edge of chip select. Every access therefore opens with a fresh chip-select cycle, and the address is set up one clock before that edge.

A write is committed when the first of write strobe or chip select rises. For this reason the controller keeps driving the data byte until both strobes are high. Each timing limit is a number of clock cycles, worked out from a clock-period parameter as the ceiling of the nanosecond value over the period, with a floor of one cycle.

Top module: `feram_bus_ctrl`

## Requirements
- R1: While reset is high and right after it, chip select, output gate and write strobe are high, the data drive-enable is low, ready is high and rd_valid is low.
- R2: The address bus holds the accepted address for at least one clock before chip select falls, and it does not change while chip select is low.
- R3: Output gate and write strobe are never low in the same cycle.
- R4: A read returns the byte stored at the requested address. It is sampled no earlier than 70 ns after chip select fell and 40 ns after output gate fell, and it appears on rd_data with rd_valid high for exactly one clock.
- R5: The write strobe stays low for at least 70 ns.
- R6: During a write, the data drive-enable is high before write strobe falls. It stays high through the cycle in which chip select returns high, so the byte is driven until both strobes are high.
- R7: Two falling edges of chip select are at least 150 ns apart.
- R8: The data drive-enable is low in the cycle before output gate falls and in every cycle output gate is low.
- R9: req_ready is low from the acceptance of a request until the cycle-time recovery ends. A request presented while req_ready is low is ignored and leaves the memory contents unchanged.
- R10: With the default parameters (5 ns clock), rd_valid rises exactly N_ASU + max(N_CE, N_OE + 1) = 15 clocks after the clock edge that accepts a read. Each N is the ceiling of its ns limit over the clock period, with a floor of one.
- R11: All 15 address bits reach the memory, so addresses 0x0000, 0x7FFF and every single-bit address hold separate bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-clock pulse marking returned read data |
| rd_data | output | 8 | Returned read byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Drive-enable for mem_dq_out |
| mem_dq_in | input | 8 | Byte returned by the memory |

## Verification
The bench's memory model returns a poison byte until both access delays have passed at the next sampling edge. A controller that samples one clock early therefore returns wrong data instead of silently passing. The model commits a write at the first rising strobe and checks that the byte is still driven when chip select rises, which catches a release of the data bus on the write-strobe edge. It also timestamps every chip-select fall, so an access that starts before the 150 ns cycle has elapsed is flagged, and so is a controller that drops ready too early and accepts a spurious request. Writes go to walking single-bit addresses, so a shortened address path shows up as aliased data.

// File: rtl/feram_pkg.sv
`timescale 1ns/1ps
package feram_pkg;

  // Number of clock cycles covering ns nanoseconds, never fewer than one.
  function automatic int ns2cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RD_CE,
    ST_RD_OE,
    ST_WR_CE,
    ST_WR_WE,
    ST_WR_HOLD,
    ST_WR_REL,
    ST_RECOV
  } fsm_e;

endpackage

// File: rtl/feram_tick.sv
`timescale 1ns/1ps
// Saturating up-counter with synchronous clear; resets to its ceiling.
module feram_tick #(
  parameter int MAX = 30,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = W'(MAX);

  always_ff @(posedge clk) begin
    if (rst)             cnt <= TOP;
    else if (clr)        cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/feram_seq.sv
`timescale 1ns/1ps
// Access sequencer: host handshake, strobe ordering and bus ownership.
module feram_seq
  import feram_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int N_ASU  = 1,
  parameter int N_CE   = 14,
  parameter int N_OE   = 8,
  parameter int N_WE   = 14,
  parameter int N_CYC  = 30,
  parameter int EL_W   = 5,
  parameter int PH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic [EL_W-1:0]   el_cnt,
  input  logic [PH_W-1:0]   ph_cnt,
  output logic              el_clr,
  output logic              ph_clr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam logic [PH_W-1:0] PH_ASU = PH_W'(N_ASU - 1);
  localparam logic [PH_W-1:0] PH_OE  = PH_W'(N_OE - 1);
  localparam logic [PH_W-1:0] PH_WE  = PH_W'(N_WE - 1);
  localparam logic [EL_W-1:0] EL_ACC = EL_W'(N_CE - 1);
  localparam logic [EL_W-1:0] EL_CYC = EL_W'(N_CYC - 1);

  fsm_e              st_q, st_d;
  logic              ce_d, oe_d, we_d, dqoe_d, rdy_d, rdv_d, wr_q, wr_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wd_d, rdd_d;

  always_comb begin
    st_d   = st_q;
    ce_d   = mem_ce_n;
    oe_d   = mem_oe_n;
    we_d   = mem_we_n;
    dqoe_d = mem_dq_oe;
    addr_d = mem_addr;
    wd_d   = mem_dq_out;
    wr_d   = wr_q;
    rdy_d  = req_ready;
    rdv_d  = 1'b0;
    rdd_d  = rd_data;
    el_clr = 1'b0;
    ph_clr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid && req_ready) begin
          rdy_d  = 1'b0;
          addr_d = req_addr;
          wd_d   = req_wdata;
          wr_d   = req_write;
          dqoe_d = req_write;  // reads release the bus here, well ahead of OE
          ph_clr = 1'b1;
          st_d   = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (ph_cnt >= PH_ASU) begin
          ce_d   = 1'b0;
          el_clr = 1'b1;
          ph_clr = 1'b1;
          st_d   = wr_q ? ST_WR_CE : ST_RD_CE;
        end
      end
      ST_RD_CE: begin
        oe_d   = 1'b0;
        ph_clr = 1'b1;
        st_d   = ST_RD_OE;
      end
      ST_RD_OE: begin
        if ((ph_cnt >= PH_OE) && (el_cnt >= EL_ACC)) begin
          rdv_d = 1'b1;
          rdd_d = mem_dq_in;
          oe_d  = 1'b1;
          ce_d  = 1'b1;
          st_d  = ST_RECOV;
        end
      end
      ST_WR_CE: begin
        we_d   = 1'b0;
        ph_clr = 1'b1;
        st_d   = ST_WR_WE;
      end
      ST_WR_WE: begin
        if (ph_cnt >= PH_WE) begin
          we_d = 1'b1;
          st_d = ST_WR_HOLD;
        end
      end
      ST_WR_HOLD: begin
        ce_d = 1'b1;
        st_d = ST_WR_REL;
      end
      ST_WR_REL: begin
        dqoe_d = 1'b0;
        st_d   = ST_RECOV;
      end
      ST_RECOV: begin
        if (el_cnt >= EL_CYC) begin
          rdy_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      wr_q       <= 1'b0;
      req_ready  <= 1'b1;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      st_q       <= st_d;
      mem_ce_n   <= ce_d;
      mem_oe_n   <= oe_d;
      mem_we_n   <= we_d;
      mem_dq_oe  <= dqoe_d;
      mem_addr   <= addr_d;
      mem_dq_out <= wd_d;
      wr_q       <= wr_d;
      req_ready  <= rdy_d;
      rd_valid   <= rdv_d;
      rd_data    <= rdd_d;
    end
  end

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |-> !req_ready);  // R9
  AST_RDV_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !wr_q);  // R4
endmodule

// File: rtl/feram_bus_ctrl.sv
`timescale 1ns/1ps
module feram_bus_ctrl
  import feram_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_ASU_NS      = 0,
  parameter int T_ACC_CE_NS   = 70,
  parameter int T_ACC_OE_NS   = 40,
  parameter int T_WE_NS       = 70,
  parameter int T_CYC_NS      = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int N_ASU  = ns2cyc(T_ASU_NS, CLK_PERIOD_NS);
  localparam int N_CE   = ns2cyc(T_ACC_CE_NS, CLK_PERIOD_NS);
  localparam int N_OE   = ns2cyc(T_ACC_OE_NS, CLK_PERIOD_NS);
  localparam int N_WE   = ns2cyc(T_WE_NS, CLK_PERIOD_NS);
  localparam int N_CYC  = ns2cyc(T_CYC_NS, CLK_PERIOD_NS);
  localparam int EL_MAX = imax(N_CYC, N_CE);
  localparam int PH_MAX = imax(N_ASU, imax(N_OE, N_WE));
  localparam int EL_W   = $clog2(EL_MAX + 1);
  localparam int PH_W   = $clog2(PH_MAX + 1);

  logic [EL_W-1:0] el_cnt;
  logic [PH_W-1:0] ph_cnt;
  logic            el_clr, ph_clr;

  // Time since chip select fell: read access delay and cycle recovery.
  feram_tick #(.MAX(EL_MAX), .W(EL_W)) u_el (
    .clk(clk), .rst(rst), .clr(el_clr), .cnt(el_cnt));

  // Time in the current phase: setup, output-gate delay, write pulse.
  feram_tick #(.MAX(PH_MAX), .W(PH_W)) u_ph (
    .clk(clk), .rst(rst), .clr(ph_clr), .cnt(ph_cnt));

  feram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_ASU(N_ASU), .N_CE(N_CE),
    .N_OE(N_OE), .N_WE(N_WE), .N_CYC(N_CYC), .EL_W(EL_W), .PH_W(PH_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .el_cnt(el_cnt), .ph_cnt(ph_cnt), .el_clr(el_clr), .ph_clr(ph_clr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // Independent interval counters used only by the assertions below.
  localparam int GW = $clog2(N_CYC + 1);
  localparam int WW = $clog2(N_WE + 1);
  localparam logic [GW-1:0] GAP_TOP = GW'(N_CYC);
  localparam logic [WW-1:0] WE_TOP  = WW'(N_WE);
  logic          ce_seen, we_seen;
  logic [GW-1:0] gap_cnt;
  logic [WW-1:0] wlo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_seen <= 1'b1;
      we_seen <= 1'b1;
      gap_cnt <= GAP_TOP;
      wlo_cnt <= WE_TOP;
    end else begin
      ce_seen <= mem_ce_n;
      we_seen <= mem_we_n;
      if (ce_seen && !mem_ce_n)  gap_cnt <= GW'(1);
      else if (gap_cnt != GAP_TOP) gap_cnt <= gap_cnt + 1'b1;
      if (we_seen && !mem_we_n)  wlo_cnt <= WW'(1);
      else if (wlo_cnt != WE_TOP) wlo_cnt <= wlo_cnt + 1'b1;
    end
  end

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));  // R3
  AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> $stable(mem_addr));  // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));  // R2
  AST_BUS_OFF_READ: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_dq_oe && $past(!mem_dq_oe)));  // R8
  AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);  // R6
  AST_CE_DRIVEN_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_ce_n) && $past(mem_dq_oe)) |-> mem_dq_oe);  // R6
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);  // R4
  AST_CYCLE_TIME: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> (gap_cnt >= GAP_TOP));  // R7
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (wlo_cnt >= WE_TOP));  // R5
  AST_BUSY_LOW: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !req_ready);  // R9
endmodule

// File: tb/sim_feram_bus_ctrl.sv
`timescale 1ns/1ps
module sim_feram_bus_ctrl;
  localparam int  PER    = 5;
  localparam real HALF   = 2.5;
  localparam int  N_ASU  = 1;
  localparam int  N_CE   = (70 + PER - 1) / PER;
  localparam int  N_OE   = (40 + PER - 1) / PER;
  localparam int  RD_LAT = N_ASU + ((N_CE > N_OE + 1) ? N_CE : N_OE + 1);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  always #(HALF) clk = ~clk;

  feram_bus_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // ---------------- memory model and pin-level timing checks ----------------
  logic [7:0] dev_mem [int];
  logic [7:0] ref_mem [int];
  bit pce = 1, pwe = 1, poe = 1, pdqoe = 0, in_wr = 0, prdv = 0;
  logic [14:0] paddr = '0, lat = '0;
  logic [7:0]  pdq = '0;
  realtime t_ce = -1000.0, t_oe = 0.0, t_we = 0.0;

  always @(negedge clk) if (!rst) begin
    realtime tedge;
    tedge = $realtime - HALF;
    if (pce && !mem_ce_n) begin
      chk(tedge - t_ce >= 150.0, "R7", "chip select fall spacing (ns)",
          int'(tedge - t_ce), 150);
      chk(mem_addr == paddr, "R2", "address setup before chip select", mem_addr, paddr);
      t_ce = tedge;
      lat  = mem_addr;
    end
    if (!pce && !mem_ce_n && mem_addr != paddr)
      chk(0, "R2", "address moved while chip select low", mem_addr, paddr);
    if (poe && !mem_oe_n) begin
      t_oe = tedge;
      chk(!pdqoe && !mem_dq_oe, "R8", "bus released before output gate", pdqoe, 0);
    end
    if (!mem_oe_n && mem_dq_oe) chk(0, "R8", "bus driven with output gate low", 1, 0);
    if (!mem_oe_n && !mem_we_n) chk(0, "R3", "output gate and write strobe both low", 1, 0);
    if (!mem_ce_n && req_ready) chk(0, "R9", "ready high during access", 1, 0);
    if (pwe && !mem_we_n) begin
      t_we  = tedge;
      in_wr = 1;
      chk(pdqoe && mem_dq_oe, "R6", "data driven before write strobe", pdqoe, 1);
    end
    if (!pwe && mem_we_n)
      chk(tedge - t_we >= 70.0, "R5", "write strobe width (ns)", int'(tedge - t_we), 70);
    if (!pce && !pwe && (mem_we_n || mem_ce_n)) begin
      chk(pdqoe, "R6", "data driven at commit", pdqoe, 1);
      dev_mem[int'(lat)] = pdq;
    end
    if (!pce && mem_ce_n && in_wr) begin
      chk(mem_dq_oe, "R6", "data still driven as chip select rises", mem_dq_oe, 1);
      in_wr = 0;
    end
    if (!mem_ce_n && !mem_oe_n && ($realtime + HALF >= t_ce + 70.0)
        && ($realtime + HALF >= t_oe + 40.0))
      mem_dq_in = dev_mem.exists(int'(lat)) ? dev_mem[int'(lat)] : 8'h00;
    else
      mem_dq_in = 8'hEE;
    pce = mem_ce_n; pwe = mem_we_n; poe = mem_oe_n;
    paddr = mem_addr; pdq = mem_dq_out; pdqoe = mem_dq_oe;
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [7:0] d; int a; longint c; } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) if (!rst) begin
    if (prdv && rd_valid) chk(0, "R4", "rd_valid longer than one clock", 1, 0);
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R4", "unexpected rd_valid", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rd_data == e.d, "R4", $sformatf("read data @%0h", e.a), rd_data, e.d);
        chk(cyc - e.c == RD_LAT, "R10", "read latency (clocks)", int'(cyc - e.c), RD_LAT);
      end
    end
    prdv = rd_valid;
  end

  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    if (w) ref_mem[int'(a)] = d;
    else begin
      exp_t e;
      e.d = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
      e.a = int'(a);
      e.c = cyc;
      exp_q.push_back(e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes high in reset",
        {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(!mem_dq_oe && req_ready && !rd_valid, "R1", "dq_oe/ready/rd_valid in reset",
        {mem_dq_oe, req_ready, rd_valid}, 3'b010);
    rst = 0;
    @(negedge clk);
    chk(mem_ce_n && req_ready && !mem_dq_oe, "R1", "idle after reset",
        {mem_ce_n, req_ready, mem_dq_oe}, 3'b110);

    // R11: extreme addresses
    issue(1, 15'h0000, 8'h5A);
    issue(1, 15'h7FFF, 8'hA5);
    issue(0, 15'h0000, 8'h00);
    issue(0, 15'h7FFF, 8'h00);
    // R11: walking single-bit addresses
    for (int i = 0; i < 15; i++) issue(1, 15'(1 << i), 8'(i * 17 + 3));
    for (int i = 0; i < 15; i++) issue(0, 15'(1 << i), 8'h00);
    // never-written location reads zero
    issue(0, 15'h1234, 8'h00);
    // overwrite then read back, read-after-write back to back
    issue(1, 15'h0000, 8'h3C);
    issue(0, 15'h0000, 8'h00);
    issue(1, 15'h2AAA, 8'hFF);
    issue(0, 15'h2AAA, 8'h00);
    // R9: request while busy is ignored
    issue(1, 15'h0100, 8'h11);
    req_valid = 1; req_write = 1; req_addr = 15'h0200; req_wdata = 8'hC3;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!req_ready, "R9", "ready low while busy", req_ready, 0);
    end
    req_valid = 0;
    issue(0, 15'h0200, 8'h00);
    issue(0, 15'h0100, 8'h00);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(req_ready && mem_ce_n, "R9", "ready returns after recovery",
        {req_ready, mem_ce_n}, 2'b11);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end
endmodule